// File: doc/BRIEF.md
# Split Read/Write Bank Window Mapper

This block lets a host reach a display memory far larger than its own 64 KB memory window. Two byte-wide I/O ports form an indexed register file. The host first writes a register number to the index port. It then reads or writes that register through the data port. The only register implemented here is the bank register. It carries two 3-bit bank numbers: one applies to host reads and the other to host writes. It also carries one spare control flag, which is only stored.

Each host memory access that falls inside the fixed window segment becomes a registered request on a synchronous display-memory port. The address of that request is the selected bank number placed above the 16-bit window offset, which gives a 19-bit address. A read access uses the read bank and a write access uses the write bank. The host can therefore copy between two 64 KB regions of display memory with plain move instructions. Accesses to any other segment produce no memory request.

Top module: `banked_window_mapper`

## Requirements
- R1: After synchronous reset, the index register and the bank register are 00h, `dm_en` and `io_rvalid` are low, and both banks select bank 0.
- R2: A write to I/O address 03C4h loads the index register. A read of 03C4h returns the index on `io_rdata`, with `io_rvalid` high, one cycle after the request.
- R3: With index 06h selected, a data-port (03C5h) write stores bits 6:0 of the byte. Bits 2:0 are the read bank, bits 5:3 are the write bank, and bit 6 is a flag that is kept. A data-port read returns the stored value, and bit 7 always reads 0.
- R4: With any index other than 06h, a data-port read returns 00h and a data-port write leaves the bank register unchanged.
- R5: A host read at segment A000h and offset `o` produces, one cycle later, `dm_en`=1, `dm_we`=0 and `dm_addr`={read bank, `o`}. The write bank has no influence.
- R6: A host write at segment A000h and offset `o` produces, one cycle later, `dm_en`=1, `dm_we`=1, `dm_addr`={write bank, `o`} and `dm_wdata` equal to the host data.
- R7: A host access to any segment other than A000h, or a cycle with no host access, leaves `dm_en` low in the following cycle.
- R8: An I/O read of any address other than 03C4h or 03C5h returns 00h. An I/O write to any such address changes neither the index nor the bank register.
- R9: The flag in bit 6 has no effect on address translation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_req | input | 1 | I/O access strobe |
| io_we | input | 1 | I/O access is a write |
| io_addr | input | 16 | I/O port address |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | I/O read data, registered |
| io_rvalid | output | 1 | I/O read data valid, one cycle after a read |
| mem_req | input | 1 | Host memory access strobe |
| mem_we | input | 1 | Host memory access is a write |
| mem_seg | input | 16 | Host segment of the access |
| mem_off | input | 16 | Offset within the segment |
| mem_wdata | input | 8 | Host write data |
| dm_en | output | 1 | Display-memory request enable |
| dm_we | output | 1 | Display-memory write enable |
| dm_addr | output | 19 | Display-memory byte address |
| dm_wdata | output | 8 | Display-memory write data |

## Verification
The bench sweeps every value of the index register. This separates the one decoded index from the 255 that must read 00h and must not change the bank register. It also writes all 256 bytes to the bank register to check that bit 7 is masked and that bits 6:0, the flag included, are kept. All 64 pairs of read and write banks are then combined with offsets at both ends of the window and in its middle, using both reads and writes, with the flag set and clear. A swap of the two bank fields, a dropped offset bit or a flag that leaks into the address each give a wrong `dm_addr`. Segments next to A000h and far from it, idle cycles, and I/O ports next to the pair complete the negative cases.

// File: rtl/mapper_pkg.sv
package mapper_pkg;
  // Source selected for the registered I/O read data.
  typedef enum logic [1:0] {
    RSEL_ZERO  = 2'd0,
    RSEL_INDEX = 2'd1,
    RSEL_BANK  = 2'd2
  } rsel_e;

  // Keeps only the implemented low bits of a register image.
  function automatic logic [7:0] keep_mask(input int unsigned nbits);
    logic [7:0] m;
    m = '0;
    for (int i = 0; i < 8; i++) begin
      if (i < nbits) m[i] = 1'b1;
    end
    return m;
  endfunction
endpackage

// File: rtl/mapper_regfile.sv
module mapper_regfile
  import mapper_pkg::*;
#(
  parameter int unsigned           IO_AW     = 16,
  parameter int unsigned           DW        = 8,
  parameter int unsigned           BANK_W    = 3,
  parameter logic [IO_AW-1:0]      IDX_PORT  = 16'h03C4,
  parameter logic [IO_AW-1:0]      DATA_PORT = 16'h03C5,
  parameter logic [DW-1:0]         BANK_IDX  = 8'h06
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              io_req,
  input  logic              io_we,
  input  logic [IO_AW-1:0]  io_addr,
  input  logic [DW-1:0]     io_wdata,
  output logic [DW-1:0]     io_rdata,
  output logic              io_rvalid,
  output logic [BANK_W-1:0] rd_bank,
  output logic [BANK_W-1:0] wr_bank,
  output logic [DW-1:0]     index_q,
  output logic [DW-1:0]     bank_q
);
  // Two bank fields plus one stored flag bit.
  localparam int unsigned STORED_BITS = 2 * BANK_W + 1;
  localparam logic [DW-1:0] BANK_MASK = DW'(keep_mask(STORED_BITS));

  logic hit_idx, hit_data, bank_sel;
  rsel_e rsel;

  always_comb begin
    hit_idx  = io_req && (io_addr == IDX_PORT);
    hit_data = io_req && (io_addr == DATA_PORT);
    bank_sel = (index_q == BANK_IDX);
    rsel     = RSEL_ZERO;
    if (hit_idx)                rsel = RSEL_INDEX;
    else if (hit_data && bank_sel) rsel = RSEL_BANK;
  end

  // Index and bank registers.
  always_ff @(posedge clk) begin
    if (rst) begin
      index_q <= '0;
      bank_q  <= '0;
    end else if (io_we) begin
      if (hit_idx)                index_q <= io_wdata;
      if (hit_data && bank_sel)   bank_q  <= io_wdata & BANK_MASK;
    end
  end

  // Registered read-back path.
  always_ff @(posedge clk) begin
    if (rst) begin
      io_rdata  <= '0;
      io_rvalid <= 1'b0;
    end else begin
      io_rvalid <= io_req && !io_we;
      unique case (rsel)
        RSEL_INDEX: io_rdata <= index_q;
        RSEL_BANK:  io_rdata <= bank_q;
        default:    io_rdata <= '0;
      endcase
    end
  end

  assign rd_bank = bank_q[BANK_W-1:0];
  assign wr_bank = bank_q[2*BANK_W-1:BANK_W];
endmodule

// File: rtl/mapper_xlate.sv
module mapper_xlate #(
  parameter int unsigned           SEG_W   = 16,
  parameter int unsigned           OFF_W   = 16,
  parameter int unsigned           BANK_W  = 3,
  parameter int unsigned           DW      = 8,
  parameter logic [SEG_W-1:0]      WIN_SEG = 16'hA000
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       mem_req,
  input  logic                       mem_we,
  input  logic [SEG_W-1:0]           mem_seg,
  input  logic [OFF_W-1:0]           mem_off,
  input  logic [DW-1:0]              mem_wdata,
  input  logic [BANK_W-1:0]          rd_bank,
  input  logic [BANK_W-1:0]          wr_bank,
  output logic                       dm_en,
  output logic                       dm_we,
  output logic [BANK_W+OFF_W-1:0]    dm_addr,
  output logic [DW-1:0]              dm_wdata
);
  localparam int unsigned ADDR_W = BANK_W + OFF_W;

  logic              in_win;
  logic [BANK_W-1:0] use_bank;
  logic [ADDR_W-1:0] next_addr;

  always_comb begin
    in_win    = mem_req && (mem_seg == WIN_SEG);
    use_bank  = mem_we ? wr_bank : rd_bank;
    next_addr = {use_bank, mem_off};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dm_en <= 1'b0;
      dm_we <= 1'b0;
    end else begin
      dm_en <= in_win;
      dm_we <= in_win && mem_we;
    end
  end

  // Address and data need no reset; they are qualified by dm_en.
  always_ff @(posedge clk) begin
    if (in_win) begin
      dm_addr <= next_addr;
      if (mem_we) dm_wdata <= mem_wdata;
    end
  end
endmodule

// File: rtl/banked_window_mapper.sv
module banked_window_mapper #(
  parameter int unsigned           IO_AW     = 16,
  parameter int unsigned           DW        = 8,
  parameter int unsigned           BANK_W    = 3,
  parameter int unsigned           SEG_W     = 16,
  parameter int unsigned           OFF_W     = 16,
  parameter logic [IO_AW-1:0]      IDX_PORT  = 16'h03C4,
  parameter logic [IO_AW-1:0]      DATA_PORT = 16'h03C5,
  parameter logic [DW-1:0]         BANK_IDX  = 8'h06,
  parameter logic [SEG_W-1:0]      WIN_SEG   = 16'hA000,
  localparam int unsigned          ADDR_W    = BANK_W + OFF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              io_req,
  input  logic              io_we,
  input  logic [IO_AW-1:0]  io_addr,
  input  logic [DW-1:0]     io_wdata,
  output logic [DW-1:0]     io_rdata,
  output logic              io_rvalid,
  input  logic              mem_req,
  input  logic              mem_we,
  input  logic [SEG_W-1:0]  mem_seg,
  input  logic [OFF_W-1:0]  mem_off,
  input  logic [DW-1:0]     mem_wdata,
  output logic              dm_en,
  output logic              dm_we,
  output logic [ADDR_W-1:0] dm_addr,
  output logic [DW-1:0]     dm_wdata
);
  logic [BANK_W-1:0] rd_bank, wr_bank;
  logic [DW-1:0]     index_q, bank_q;

  mapper_regfile #(
    .IO_AW(IO_AW), .DW(DW), .BANK_W(BANK_W),
    .IDX_PORT(IDX_PORT), .DATA_PORT(DATA_PORT), .BANK_IDX(BANK_IDX)
  ) u_regs (
    .clk(clk), .rst(rst),
    .io_req(io_req), .io_we(io_we), .io_addr(io_addr), .io_wdata(io_wdata),
    .io_rdata(io_rdata), .io_rvalid(io_rvalid),
    .rd_bank(rd_bank), .wr_bank(wr_bank),
    .index_q(index_q), .bank_q(bank_q)
  );

  mapper_xlate #(
    .SEG_W(SEG_W), .OFF_W(OFF_W), .BANK_W(BANK_W), .DW(DW), .WIN_SEG(WIN_SEG)
  ) u_xlate (
    .clk(clk), .rst(rst),
    .mem_req(mem_req), .mem_we(mem_we), .mem_seg(mem_seg),
    .mem_off(mem_off), .mem_wdata(mem_wdata),
    .rd_bank(rd_bank), .wr_bank(wr_bank),
    .dm_en(dm_en), .dm_we(dm_we), .dm_addr(dm_addr), .dm_wdata(dm_wdata)
  );
endmodule

// File: rtl/mapper_checker.sv
module mapper_checker #(
  parameter int unsigned      IO_AW     = 16,
  parameter int unsigned      DW        = 8,
  parameter int unsigned      BANK_W    = 3,
  parameter int unsigned      SEG_W     = 16,
  parameter int unsigned      OFF_W     = 16,
  parameter logic [IO_AW-1:0] IDX_PORT  = 16'h03C4,
  parameter logic [IO_AW-1:0] DATA_PORT = 16'h03C5,
  parameter logic [DW-1:0]    BANK_IDX  = 8'h06,
  parameter logic [SEG_W-1:0] WIN_SEG   = 16'hA000
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    io_req,
  input logic                    io_we,
  input logic [IO_AW-1:0]        io_addr,
  input logic [DW-1:0]           io_wdata,
  input logic [DW-1:0]           io_rdata,
  input logic                    io_rvalid,
  input logic                    mem_req,
  input logic                    mem_we,
  input logic [SEG_W-1:0]        mem_seg,
  input logic [OFF_W-1:0]        mem_off,
  input logic                    dm_en,
  input logic                    dm_we,
  input logic [BANK_W+OFF_W-1:0] dm_addr,
  input logic [DW-1:0]           index_q,
  input logic [DW-1:0]           bank_q
);
  localparam logic [DW-1:0] STORE_MASK = DW'((1 << (2*BANK_W+1)) - 1);

  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!dm_en && !io_rvalid));

  assert_index_load_R2: assert property (@(posedge clk) disable iff (rst)
    (io_req && io_we && io_addr == IDX_PORT) |=> (index_q == $past(io_wdata)));

  assert_bank_store_R3: assert property (@(posedge clk) disable iff (rst)
    (io_req && io_we && io_addr == DATA_PORT && index_q == BANK_IDX)
      |=> (bank_q == ($past(io_wdata) & STORE_MASK)));

  assert_unimpl_read_R4: assert property (@(posedge clk) disable iff (rst)
    (io_req && !io_we && io_addr == DATA_PORT && index_q != BANK_IDX)
      |=> (io_rvalid && io_rdata == '0));

  assert_read_map_R5: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_we && mem_seg == WIN_SEG)
      |=> (dm_en && !dm_we &&
           dm_addr == {$past(bank_q[BANK_W-1:0]), $past(mem_off)}));

  assert_write_map_R6: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we && mem_seg == WIN_SEG)
      |=> (dm_en && dm_we &&
           dm_addr == {$past(bank_q[2*BANK_W-1:BANK_W]), $past(mem_off)}));

  assert_no_stray_R7: assert property (@(posedge clk) disable iff (rst)
    (!mem_req || mem_seg != WIN_SEG) |=> !dm_en);
endmodule

bind banked_window_mapper mapper_checker #(
  .IO_AW(IO_AW), .DW(DW), .BANK_W(BANK_W), .SEG_W(SEG_W), .OFF_W(OFF_W),
  .IDX_PORT(IDX_PORT), .DATA_PORT(DATA_PORT), .BANK_IDX(BANK_IDX), .WIN_SEG(WIN_SEG)
) u_chk (
  .clk(clk), .rst(rst),
  .io_req(io_req), .io_we(io_we), .io_addr(io_addr), .io_wdata(io_wdata),
  .io_rdata(io_rdata), .io_rvalid(io_rvalid),
  .mem_req(mem_req), .mem_we(mem_we), .mem_seg(mem_seg), .mem_off(mem_off),
  .dm_en(dm_en), .dm_we(dm_we), .dm_addr(dm_addr),
  .index_q(index_q), .bank_q(bank_q)
);

// File: tb/tb_banked_window_mapper.sv
`timescale 1ns/1ps
module tb_banked_window_mapper;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        io_req = 1'b0, io_we = 1'b0;
  logic [15:0] io_addr = '0;
  logic [7:0]  io_wdata = '0;
  logic [7:0]  io_rdata;
  logic        io_rvalid;
  logic        mem_req = 1'b0, mem_we = 1'b0;
  logic [15:0] mem_seg = '0, mem_off = '0;
  logic [7:0]  mem_wdata = '0;
  logic        dm_en, dm_we;
  logic [18:0] dm_addr;
  logic [7:0]  dm_wdata;

  int n_cmp = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  banked_window_mapper dut (
    .clk(clk), .rst(rst),
    .io_req(io_req), .io_we(io_we), .io_addr(io_addr), .io_wdata(io_wdata),
    .io_rdata(io_rdata), .io_rvalid(io_rvalid),
    .mem_req(mem_req), .mem_we(mem_we), .mem_seg(mem_seg),
    .mem_off(mem_off), .mem_wdata(mem_wdata),
    .dm_en(dm_en), .dm_we(dm_we), .dm_addr(dm_addr), .dm_wdata(dm_wdata)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic io_wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    io_req = 1'b1; io_we = 1'b1; io_addr = a; io_wdata = d;
    @(negedge clk);
    io_req = 1'b0; io_we = 1'b0;
  endtask

  task automatic io_rd(input logic [15:0] a, output logic [7:0] d, output logic v);
    @(negedge clk);
    io_req = 1'b1; io_we = 1'b0; io_addr = a;
    @(negedge clk);
    io_req = 1'b0;
    d = io_rdata; v = io_rvalid;
  endtask

  task automatic mem_acc(input logic [15:0] s, input logic [15:0] o, input logic w,
                         input logic [7:0] wd);
    @(negedge clk);
    mem_req = 1'b1; mem_we = w; mem_seg = s; mem_off = o; mem_wdata = wd;
    @(negedge clk);
    mem_req = 1'b0; mem_we = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] d;
    logic v;
    logic [15:0] offs [3];
    offs[0] = 16'h0000; offs[1] = 16'h5A3C; offs[2] = 16'hFFFF;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk("R1 dm_en", {31'b0, dm_en}, 32'd0);
    chk("R1 io_rvalid", {31'b0, io_rvalid}, 32'd0);
    io_rd(16'h03C4, d, v);
    chk("R1 index", {24'b0, d}, 32'h00);
    io_wr(16'h03C4, 8'h06);
    io_rd(16'h03C5, d, v);
    chk("R1 bank", {24'b0, d}, 32'h00);
    mem_acc(16'hA000, 16'h1234, 1'b0, 8'h00);
    chk("R1 read bank0", {13'b0, dm_addr}, 32'h01234);
    mem_acc(16'hA000, 16'h4321, 1'b1, 8'h77);
    chk("R1 write bank0", {13'b0, dm_addr}, 32'h04321);

    // R3: all 256 byte values into the bank register
    for (int b = 0; b < 256; b++) begin
      io_wr(16'h03C5, 8'(b));
      io_rd(16'h03C5, d, v);
      chk("R3 bank readback", {24'b0, d}, 32'(b & 8'h7F));
      chk("R3 rvalid", {31'b0, v}, 32'd1);
    end

    // R2 / R4: every index value
    io_wr(16'h03C4, 8'h06);
    io_wr(16'h03C5, 8'h5D);
    for (int i = 0; i < 256; i++) begin
      io_wr(16'h03C4, 8'(i));
      io_rd(16'h03C4, d, v);
      chk("R2 index readback", {24'b0, d}, 32'(i));
      chk("R2 rvalid", {31'b0, v}, 32'd1);
      io_rd(16'h03C5, d, v);
      if (i == 6) chk("R3 data at bank index", {24'b0, d}, 32'h5D);
      else        chk("R4 unimplemented read", {24'b0, d}, 32'h00);
      if (i != 6) io_wr(16'h03C5, 8'hA2);
    end
    io_wr(16'h03C4, 8'h06);
    io_rd(16'h03C5, d, v);
    chk("R4 bank untouched", {24'b0, d}, 32'h5D);

    // R8: neighbouring and distant I/O ports
    io_wr(16'h03C3, 8'h11);
    io_wr(16'h03C6, 8'h22);
    io_wr(16'h0000, 8'h33);
    io_rd(16'h03C3, d, v);
    chk("R8 read other port", {24'b0, d}, 32'h00);
    chk("R8 rvalid other port", {31'b0, v}, 32'd1);
    io_rd(16'h13C5, d, v);
    chk("R8 read aliased port", {24'b0, d}, 32'h00);
    io_rd(16'h03C4, d, v);
    chk("R8 index untouched", {24'b0, d}, 32'h06);
    io_rd(16'h03C5, d, v);
    chk("R8 bank untouched", {24'b0, d}, 32'h5D);

    // R5 / R6 / R9: all bank pairs, flag clear and set, three offsets
    for (int fl = 0; fl < 2; fl++) begin
      for (int rb = 0; rb < 8; rb++) begin
        for (int wb = 0; wb < 8; wb++) begin
          io_wr(16'h03C5, 8'((fl << 6) | (wb << 3) | rb));
          for (int k = 0; k < 3; k++) begin
            mem_acc(16'hA000, offs[k], 1'b0, 8'h00);
            chk("R5 dm_en", {31'b0, dm_en}, 32'd1);
            chk("R5 dm_we", {31'b0, dm_we}, 32'd0);
            chk("R5 R9 read addr", {13'b0, dm_addr}, 32'(rb * 65536 + offs[k]));
            mem_acc(16'hA000, offs[k], 1'b1, 8'(rb * 16 + wb + k));
            chk("R6 dm_we", {31'b0, dm_we}, 32'd1);
            chk("R6 R9 write addr", {13'b0, dm_addr}, 32'(wb * 65536 + offs[k]));
            chk("R6 wdata", {24'b0, dm_wdata}, 32'((rb * 16 + wb + k) & 8'hFF));
          end
        end
      end
    end

    // R7: outside the window and idle cycles
    mem_acc(16'h9FFF, 16'h0010, 1'b0, 8'h00);
    chk("R7 seg below", {31'b0, dm_en}, 32'd0);
    mem_acc(16'hA001, 16'h0010, 1'b1, 8'h55);
    chk("R7 seg above", {31'b0, dm_en}, 32'd0);
    mem_acc(16'hB800, 16'hFFFF, 1'b1, 8'h55);
    chk("R7 seg text", {31'b0, dm_en}, 32'd0);
    mem_acc(16'h0000, 16'h0000, 1'b0, 8'h00);
    chk("R7 seg zero", {31'b0, dm_en}, 32'd0);
    @(negedge clk);
    chk("R7 idle", {31'b0, dm_en}, 32'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule